// File: doc/BRIEF.md
# Port Expander Register Write Engine

This block is the write side of a 40-line port expander on an I2C bus. A bit-level I2C slave sits in front of it. That slave reports START and STOP conditions, hands over each received byte with a one-cycle valid strobe, and later pulses a strobe at the acknowledge slot of that byte. The engine decides the acknowledge for each byte. The first byte after START is the device address. The byte after an accepted address is a command byte that selects a register pointer. Every byte after that is written into the register the pointer selects.

The engine holds four register groups of five 8-bit banks each: output values, polarity inversion, direction (configuration) and interrupt mask. With auto-increment on, the pointer steps through the banks of one group and wraps back to that group's bank 0. Each data byte is committed on its own acknowledge strobe, not at STOP. The 40 output values are presented with per-pin drive enables. The polarity, direction and mask contents go to the neighbouring input and interrupt logic.

Top module: `ioexp_wr_engine`

## Requirements
- R1: An address byte is acknowledged only when its bits 7:1 equal binary 0100 followed by `dev_pins_i[2:0]` and its bit 0 (read/write) is 0. A rejected address gets no acknowledge, and every byte that follows is ignored, with no acknowledge, until the next START.
- R2: The first byte after an accepted address is the command. It is acknowledged. Bit 7 is the auto-increment flag and bits 5:0 are the pointer. Bits 5:3 select the group: 1 = output values, 2 = polarity, 3 = direction, 4 = mask. Bits 2:0 select the bank. Bank n drives lines 8n+7..8n.
- R3: With auto-increment 0, every data byte of the transfer writes the same register.
- R4: With auto-increment 1, each committed data byte moves the pointer to the next bank of the same group. From bank 4 it wraps to bank 0, so a sixth byte overwrites the first.
- R5: A data byte changes its register only at its acknowledge strobe. The register outputs show the new value in the cycle after that strobe and are unchanged before it.
- R6: Data bytes whose pointer has bank field 5 to 7, or group field 0 or 5 to 7, are acknowledged but change no register. The pointer does not move.
- R7: START makes the next byte an address byte. STOP makes the engine ignore bytes until the next START. A START inside a transfer discards an uncommitted data byte.
- R8: After reset, the output values are 0, direction bits are 1, polarity bits are 0 and mask bits are 1.
- R9: `pin_o` carries the output-value registers. Pin i is driven (`pin_en_o[i]`=1) only when direction bit i is 0 and `oe_ni` is 0.
- R10: `pol_o`, `cfg_o` and `mask_o` carry the current polarity, direction and mask registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dev_pins_i | input | 3 | Low three bits of the device address |
| bus_start_i | input | 1 | START or repeated START seen |
| bus_stop_i | input | 1 | STOP seen |
| rx_valid_i | input | 1 | A received byte is on rx_byte_i |
| rx_byte_i | input | 8 | Received byte |
| ack_slot_i | input | 1 | Acknowledge slot of the last byte |
| ack_o | output | 1 | Acknowledge decision for the byte on rx_byte_i |
| oe_ni | input | 1 | Active-low output enable |
| pin_o | output | 40 | Output-value registers |
| pin_en_o | output | 40 | Per-pin drive enable |
| pol_o | output | 40 | Polarity inversion registers |
| cfg_o | output | 40 | Direction registers, 1 = input |
| mask_o | output | 40 | Interrupt mask registers |

## Verification
The in-line properties check the cycle-level rules on every clock:
- no acknowledge without a byte and none while a transfer is rejected;
- START and STOP move the sequencer to the right phase;
- a register group changes only on its write enable;
- an auto-increment step stays inside its group, and with auto-increment off the pointer holds.

Behaviours that depend on a whole transfer can only be shown by the bench's scenarios, which compare against a reference model. These are the wrap that overwrites bank 0, the reserved pointers that write nothing, the exact bank each byte lands in, and the reset contents.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;
  localparam int NUM_BANKS_DEF = 5;
  localparam int BANK_W_DEF    = 8;
  localparam int NUM_GRPS      = 4;
  localparam int PTR_W         = 6;
  localparam int BANK_IDX_W    = 3;
  localparam logic [3:0] DEV_PREFIX = 4'b0100;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_CMD  = 3'd2,
    ST_DATA = 3'd3,
    ST_SKIP = 3'd4
  } seq_state_e;
endpackage

// File: rtl/ioexp_seq.sv
module ioexp_seq
  import ioexp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        dev_pins_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ack_slot_i,
  output logic              ack_o,
  output logic              cmd_load_o,
  output logic              commit_o,
  output logic [BYTE_W-1:0] wdata_o
);
  seq_state_e        state_q, state_d;
  logic              pend_q, pend_d, pend_set;
  logic [BYTE_W-1:0] data_q;
  logic              addr_hit;

  assign addr_hit = (byte_i[BYTE_W-1:1] == {DEV_PREFIX, dev_pins_i}) && !byte_i[0];

  always_comb begin
    state_d    = state_q;
    ack_o      = 1'b0;
    cmd_load_o = 1'b0;
    pend_set   = 1'b0;
    if (start_i) begin
      state_d = ST_ADDR;
    end else if (stop_i) begin
      state_d = ST_IDLE;
    end else if (valid_i) begin
      unique case (state_q)
        ST_ADDR: begin
          ack_o   = addr_hit;
          state_d = addr_hit ? ST_CMD : ST_SKIP;
        end
        ST_CMD: begin
          ack_o      = 1'b1;
          cmd_load_o = 1'b1;
          state_d    = ST_DATA;
        end
        ST_DATA: begin
          ack_o    = 1'b1;
          pend_set = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign commit_o = ack_slot_i && pend_q;
  assign wdata_o  = data_q;

  always_comb begin
    pend_d = pend_q;
    if (start_i || stop_i) pend_d = 1'b0;
    else if (pend_set)     pend_d = 1'b1;
    else if (commit_o)     pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       data_q <= '0;
    else if (pend_set) data_q <= byte_i;
  end

  assert_ack_needs_byte_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !ack_o);
  assert_skip_silent_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP && !start_i) |-> !ack_o);
  assert_start_rearms_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_ADDR && !pend_q));
  assert_stop_idles_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (state_q == ST_IDLE && !pend_q));
endmodule

// File: rtl/ioexp_ptr.sv
module ioexp_ptr
  import ioexp_pkg::*;
#(
  parameter int NUM_BANKS = NUM_BANKS_DEF,
  parameter int BYTE_W    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [BYTE_W-1:0]     cmd_i,
  input  logic                  adv_i,
  output logic [NUM_GRPS-1:0]   wr_sel_o,
  output logic [BANK_IDX_W-1:0] wr_bank_o
);
  localparam int GRP_W = PTR_W - BANK_IDX_W;

  logic [PTR_W-1:0]      ptr_q, ptr_d;
  logic                  ai_q, ai_d;
  logic [GRP_W-1:0]      grp;
  logic [BANK_IDX_W-1:0] bank, bank_nxt;
  logic                  bank_ok, wr_ok;

  assign grp     = ptr_q[PTR_W-1:BANK_IDX_W];
  assign bank    = ptr_q[BANK_IDX_W-1:0];
  assign bank_ok = int'(bank) < NUM_BANKS;

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_sel
    assign wr_sel_o[g] = bank_ok && (grp == GRP_W'(g + 1));
  end

  assign wr_ok     = |wr_sel_o;
  assign wr_bank_o = bank;
  assign bank_nxt  = (int'(bank) == NUM_BANKS - 1) ? '0 : bank + 1'b1;

  always_comb begin
    ptr_d = ptr_q;
    ai_d  = ai_q;
    if (load_i) begin
      ptr_d = cmd_i[PTR_W-1:0];
      ai_d  = cmd_i[BYTE_W-1];
    end else if (adv_i && ai_q && wr_ok) begin
      ptr_d = {grp, bank_nxt};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      ai_q  <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      ai_q  <= ai_d;
    end
  end

  assert_wrap_in_group_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && ai_q && wr_ok) |=>
      (grp == $past(grp)) && (int'(bank) < NUM_BANKS) && (bank != $past(bank)));
  assert_hold_no_ai_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !ai_q) |=> $stable(ptr_q));
  assert_reserved_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !wr_ok) |=> $stable(ptr_q));
  assert_sel_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_o));
endmodule

// File: rtl/ioexp_bank_regs.sv
module ioexp_bank_regs
  import ioexp_pkg::*;
#(
  parameter int NUM_BANKS = NUM_BANKS_DEF,
  parameter int BANK_W    = BANK_W_DEF,
  parameter bit RST_ONES  = 1'b0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [BANK_IDX_W-1:0]   bank_i,
  input  logic [BANK_W-1:0]       data_i,
  output logic [NUM_BANKS*BANK_W-1:0] bits_o
);
  localparam logic [BANK_W-1:0] RST_VAL = {BANK_W{RST_ONES}};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              en;
    logic [BANK_W-1:0] q, d;

    assign en = we_i && (bank_i == BANK_IDX_W'(b));

    always_comb begin
      d = q;
      if (en) d = data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST_VAL;
      else         q <= d;
    end

    assign bits_o[b*BANK_W +: BANK_W] = q;
  end

  assert_write_only_on_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(bits_o));
endmodule

// File: rtl/ioexp_wr_engine.sv
module ioexp_wr_engine
  import ioexp_pkg::*;
#(
  parameter int NUM_BANKS = NUM_BANKS_DEF,
  parameter int BANK_W    = BANK_W_DEF,
  localparam int LINES    = NUM_BANKS * BANK_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       dev_pins_i,
  input  logic             bus_start_i,
  input  logic             bus_stop_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             ack_slot_i,
  output logic             ack_o,
  input  logic             oe_ni,
  output logic [LINES-1:0] pin_o,
  output logic [LINES-1:0] pin_en_o,
  output logic [LINES-1:0] pol_o,
  output logic [LINES-1:0] cfg_o,
  output logic [LINES-1:0] mask_o
);
  logic [1:0]            rst_sync_q;
  logic                  rst_n;
  logic                  cmd_load, commit;
  logic [7:0]            wdata;
  logic [NUM_GRPS-1:0]   wr_sel;
  logic [BANK_IDX_W-1:0] wr_bank;
  logic [LINES-1:0]      grp_bits [NUM_GRPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  ioexp_seq #(.BYTE_W(8)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .dev_pins_i (dev_pins_i),
    .start_i    (bus_start_i),
    .stop_i     (bus_stop_i),
    .valid_i    (rx_valid_i),
    .byte_i     (rx_byte_i),
    .ack_slot_i (ack_slot_i),
    .ack_o      (ack_o),
    .cmd_load_o (cmd_load),
    .commit_o   (commit),
    .wdata_o    (wdata)
  );

  ioexp_ptr #(.NUM_BANKS(NUM_BANKS), .BYTE_W(8)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .load_i    (cmd_load),
    .cmd_i     (rx_byte_i),
    .adv_i     (commit),
    .wr_sel_o  (wr_sel),
    .wr_bank_o (wr_bank)
  );

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
    ioexp_bank_regs #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .RST_ONES  (g >= 2)
    ) u_regs (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .we_i   (commit && wr_sel[g]),
      .bank_i (wr_bank),
      .data_i (wdata[BANK_W-1:0]),
      .bits_o (grp_bits[g])
    );
  end

  assign pin_o    = grp_bits[0];
  assign pol_o    = grp_bits[1];
  assign cfg_o    = grp_bits[2];
  assign mask_o   = grp_bits[3];
  assign pin_en_o = ~grp_bits[2] & {LINES{~oe_ni}};
endmodule

// File: tb/ioexp_wr_engine_tb.sv
module ioexp_wr_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  pins;
  logic        start_s, stop_s, rx_valid, ack_slot, oe_n;
  logic [7:0]  rx_byte;
  logic        ack;
  logic [39:0] pin, pin_en, pol, cfg, mask;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 0;

  logic [7:0] m_reg [4][5];
  int         m_st;
  logic [5:0] m_ptr;
  logic       m_ai;
  logic       m_pend;
  logic [7:0] m_data;

  always #4 clk = ~clk;

  ioexp_wr_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dev_pins_i(pins),
    .bus_start_i(start_s), .bus_stop_i(stop_s),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .ack_slot_i(ack_slot),
    .ack_o(ack), .oe_ni(oe_n), .pin_o(pin), .pin_en_o(pin_en),
    .pol_o(pol), .cfg_o(cfg), .mask_o(mask)
  );

  task automatic check(input bit ok, input string tag, input logic [39:0] act,
                       input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] m_group(input int g);
    logic [39:0] v;
    for (int b = 0; b < 5; b++) v[b*8 +: 8] = m_reg[g][b];
    return v;
  endfunction

  always @(negedge clk) begin
    if (cmp_en) begin
      check(pin == m_group(0), "R5 R9 pin_o", pin, m_group(0));
      check(pol == m_group(1), "R10 pol_o", pol, m_group(1));
      check(cfg == m_group(2), "R10 cfg_o", cfg, m_group(2));
      check(mask == m_group(3), "R10 mask_o", mask, m_group(3));
      check(pin_en == (oe_n ? 40'h0 : ~m_group(2)), "R9 pin_en_o", pin_en,
            oe_n ? 40'h0 : ~m_group(2));
    end
  end

  task automatic bus_start();
    @(negedge clk); start_s = 1;
    @(posedge clk); m_st = 1; m_pend = 0;
    @(negedge clk); start_s = 0;
  endtask

  task automatic bus_stop();
    @(negedge clk); stop_s = 1;
    @(posedge clk); m_st = 0; m_pend = 0;
    @(negedge clk); stop_s = 0;
  endtask

  task automatic send(input logic [7:0] b, input string tag);
    logic exp_ack;
    int g, k;
    exp_ack = (m_st == 1) ? (b[7:1] == {4'b0100, pins} && !b[0]) :
              (m_st == 2 || m_st == 3);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    #1 check(ack == exp_ack, tag, {39'h0, ack}, {39'h0, exp_ack});
    @(posedge clk);
    case (m_st)
      1: m_st = exp_ack ? 2 : 4;
      2: begin m_ai = b[7]; m_ptr = b[5:0]; m_st = 3; end
      3: begin m_pend = 1; m_data = b; end
      default: ;
    endcase
    @(negedge clk); rx_valid = 0; ack_slot = 1;
    @(posedge clk);
    if (m_pend) begin
      g = int'(m_ptr[5:3]); k = int'(m_ptr[2:0]);
      if (g >= 1 && g <= 4 && k < 5) begin
        m_reg[g-1][k] = m_data;
        if (m_ai) m_ptr = {m_ptr[5:3], 3'(k == 4 ? 0 : k + 1)};
      end
      m_pend = 0;
    end
    @(negedge clk); ack_slot = 0;
  endtask

  task automatic set_oe(input logic v);
    @(posedge clk); #2 oe_n = v;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; pins = 3'b101; start_s = 0; stop_s = 0; rx_valid = 0;
    ack_slot = 0; oe_n = 1; rx_byte = 0;
    m_st = 0; m_ptr = 0; m_ai = 0; m_pend = 0; m_data = 0;
    for (int g = 0; g < 4; g++)
      for (int b = 0; b < 5; b++) m_reg[g][b] = (g >= 2) ? 8'hFF : 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp_en = 1;
    // R8 reset contents
    check(pin == 40'h0 && pol == 40'h0, "R8 out/pol reset", pin | pol, 40'h0);
    check(cfg == '1 && mask == '1, "R8 cfg/mask reset", cfg & mask, '1);

    // R1 wrong pins, then ignored data
    bus_start(); send(8'h48, "R1 addr mismatch"); send(8'h88, "R1 ignored");
    send(8'h5A, "R1 ignored data"); bus_stop();
    // R1 read bit set
    bus_start(); send(8'h4B, "R1 read rejected"); send(8'h08, "R1 ignored"); bus_stop();

    // R2 R4 auto-increment over output group, wrap overwrites bank 0
    bus_start(); send(8'h4A, "R1 addr ok"); send(8'h88, "R2 cmd");
    for (int i = 1; i <= 7; i++) send(8'(i * 8'h11), "R4 data");
    bus_stop();
    check(pin == 40'h55_44_33_77_66, "R4 wrap", pin, 40'h55_44_33_77_66);

    // R5 value not visible before ack strobe
    bus_start(); send(8'h4A, "R1 addr"); send(8'h09, "R2 cmd");
    @(negedge clk); rx_valid = 1; rx_byte = 8'hC3;
    @(posedge clk); m_pend = 1; m_data = 8'hC3;
    @(negedge clk); rx_valid = 0;
    check(pin[15:8] == 8'h77, "R5 before ack", {32'h0, pin[15:8]}, 40'h77);
    ack_slot = 1;
    @(posedge clk); m_reg[0][1] = 8'hC3; m_pend = 0;
    @(negedge clk); ack_slot = 0;
    check(pin[15:8] == 8'hC3, "R5 after ack", {32'h0, pin[15:8]}, 40'hC3);
    bus_stop();

    // R3 no auto-increment on direction bank 2
    bus_start(); send(8'h4A, "R1 addr"); send(8'h1A, "R2 cmd");
    send(8'h0F, "R3 data"); send(8'hF0, "R3 data"); send(8'h3C, "R3 data");
    bus_stop();
    check(cfg == 40'hFF_FF_3C_FF_FF, "R3 same reg", cfg, 40'hFF_FF_3C_FF_FF);

    // R9 output enable
    set_oe(0); repeat (2) @(posedge clk); set_oe(1); set_oe(0);

    // R10 polarity and mask with wrap from bank 3
    bus_start(); send(8'h4A, "R1 addr"); send(8'h90, "R2 cmd");
    send(8'hA5, "R10 pol"); send(8'h5A, "R10 pol"); bus_stop();
    bus_start(); send(8'h4A, "R1 addr"); send(8'hA3, "R2 cmd");
    send(8'h01, "R4 mask"); send(8'h02, "R4 mask"); send(8'h03, "R4 mask");
    bus_stop();
    check(mask == 40'h02_01_FF_FF_03, "R4 mask wrap", mask, 40'h02_01_FF_FF_03);

    // R6 reserved pointers
    bus_start(); send(8'h4A, "R1 addr"); send(8'h8D, "R2 cmd");
    send(8'hEE, "R6 data"); send(8'hEE, "R6 data"); bus_stop();
    bus_start(); send(8'h4A, "R1 addr"); send(8'h80, "R2 cmd");
    send(8'hEE, "R6 data"); bus_stop();
    bus_start(); send(8'h4A, "R1 addr"); send(8'hA8, "R2 cmd");
    send(8'hEE, "R6 data"); bus_stop();
    check(pin == 40'h55_44_33_C3_66, "R6 no change", pin, 40'h55_44_33_C3_66);

    // R7 bytes after STOP ignored; repeated START makes a fresh command
    send(8'h4A, "R7 idle"); send(8'h08, "R7 idle");
    bus_start(); send(8'h4A, "R1 addr"); send(8'h8B, "R2 cmd");
    @(negedge clk); rx_valid = 1; rx_byte = 8'h99;
    @(posedge clk); m_pend = 1; m_data = 8'h99;
    @(negedge clk); rx_valid = 0;
    bus_start();
    @(negedge clk); ack_slot = 1; @(negedge clk); ack_slot = 0;
    check(pin[31:24] == 8'h44, "R7 dropped byte", {32'h0, pin[31:24]}, 40'h44);
    send(8'h4A, "R7 addr again"); send(8'h0C, "R7 cmd"); send(8'hBE, "R7 data");
    bus_stop();
    check(pin[39:32] == 8'hBE, "R7 new cmd", {32'h0, pin[39:32]}, 40'hBE);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule